// File: doc/BRIEF.md
# Compressed block address translator

This block turns a request for one 8x8 texel block of a compressed image into the byte addresses of the fixed-size storage units that hold that block's compressed data. Blocks are compressed independently, so any one can be reached without decoding its neighbours. A request carries the word address of a per-surface pointer table, the block's column and row, the number of blocks in a row, and an id tag. The block computes the entry's location as `table + (row * blocks_per_row + column)` in 32-bit words and reads that entry. The entry gives the first unit address and the block's length in units.

The units form a singly linked list. The first word of each 128-byte unit holds the address of the next unit. The translator follows the chain and streams out one unit address per unit, each tagged with the request id. It stops when the length is used up or when it meets a zero link. Pointer-table entries arrive through a small direct-mapped cache that holds aligned groups of eight entries, so neighbouring blocks need no new table read.

All memory traffic goes through one read port, with a single read in flight at a time. A new request is held off until the current chain walk has finished. Decompression of the fetched data happens downstream.

Top module: `cblk_xlate`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. It is low from the cycle after a request is accepted until the walk for that request has finished. It is high again in the cycle in which the final unit address appears on the output.
- R2: The pointer-table entry read for a request is at word address `req_table + req_row * req_bpr + req_col`. The byte address is four times the word address. Entry bits [23:0] hold the first unit's byte address and bits [31:24] hold the length in units.
- R3: The entry cache has 8 direct-mapped lines of 8 entries each. For entry word address w, the offset is w[2:0], the line is w[5:3] and the tag is the remaining upper bits. On a miss, exactly 8 table reads are issued at the ascending byte addresses `(w with bits [2:0] cleared) * 4 + 4k`, for k = 0..7, and then the entry is used. On a hit, no table read is issued.
- R4: Unit addresses are emitted in chain order, starting with the entry's unit address. Each later address is bits [23:0] of the word read at the previous unit's byte address. The upper 8 bits of that word are ignored.
- R5: For a length L, at most L unit addresses are emitted. The link word of the L-th unit is never read.
- R6: A link value of zero ends the chain early. The unit whose link was zero is the final one emitted.
- R7: An entry with length 0 emits no unit address and returns the block to idle.
- R8: `out_last` is high on the final unit of a request and low on all others. Every emitted unit carries the id of the request that produced it on `out_id`.
- R9: Only one memory read is in flight at a time. While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address are held stable. After a read is accepted, no new read is issued until `mem_rsp_valid` returns its data.
- R10: Asserting reset returns the block to idle at once, with `req_ready` high and `out_valid` and `mem_req_valid` low. Reset also empties the entry cache, so the first request after reset refills its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_table | input | ADDR_W-2 (30) | Pointer-table base, 32-bit word address |
| req_col | input | CRD_W (10) | Block column |
| req_row | input | CRD_W (10) | Block row |
| req_bpr | input | CRD_W (10) | Blocks per row |
| req_id | input | ID_W (8) | Tag returned with each unit address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | ADDR_W (32) | Byte address of the read |
| mem_rsp_valid | input | 1 | Read data valid for one cycle |
| mem_rsp_data | input | 32 | Read data |
| out_valid | output | 1 | Unit address valid, one-cycle pulse |
| out_addr | output | 24 | Unit byte address |
| out_id | output | ID_W (8) | Id of the owning request |
| out_last | output | 1 | Final unit of this request |

## Verification
Two events can share a clock edge: the final unit address of one request, and the acceptance of the next request in the same cycle that `req_ready` returns. The bench provokes this by presenting each new request at the first falling edge after `req_ready` rises. It then judges that the last unit of the earlier walk still carries the earlier id and the last flag, and that the new walk's outputs carry only the new id. A second overlap comes from running some requests against a memory that drops `mem_req_ready` on alternate cycles and delays its responses, so that cache refills and link reads are stretched. Against that memory the bench checks the order and count of table and link reads.

// File: rtl/cblk_pkg.sv
package cblk_pkg;
  localparam int UNIT_W = 24;
  localparam int LEN_W  = 8;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [UNIT_W-1:0] unit;
  } ptr_ent_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FREQ,
    ST_FWAIT,
    ST_WALK,
    ST_NREQ,
    ST_NWAIT
  } xl_state_t;
endpackage

// File: rtl/cblk_addr_gen.sv
module cblk_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int CRD_W  = 10
) (
  input  logic [ADDR_W-3:0] table_w,
  input  logic [CRD_W-1:0]  col,
  input  logic [CRD_W-1:0]  row,
  input  logic [CRD_W-1:0]  bpr,
  output logic [ADDR_W-3:0] ent_w
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;

  // Linear block number scaled to one word per entry
  assign idx   = IDX_W'(row) * IDX_W'(bpr) + IDX_W'(col);
  assign ent_w = table_w + idx;
endmodule

// File: rtl/cblk_ptr_cache.sv
module cblk_ptr_cache #(
  parameter int ADDR_W  = 32,
  parameter int LINES   = 8,
  parameter int ENTRIES = 8,
  parameter int WORD_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-3:0] lk_w,
  output logic              lk_hit,
  output logic [WORD_W-1:0] lk_data,
  input  logic              fill_start,
  input  logic              fill_we,
  input  logic [ADDR_W-3:0] fill_w,
  input  logic [WORD_W-1:0] fill_data,
  input  logic              fill_done
);
  localparam int SET_W = $clog2(LINES);
  localparam int OFF_W = $clog2(ENTRIES);
  localparam int TAG_L = OFF_W + SET_W;
  localparam int TAG_W = ADDR_W - 2 - TAG_L;

  logic [WORD_W-1:0] data_q [LINES][ENTRIES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  vld_q;
  logic [LINES-1:0]  hit_vec;

  logic [SET_W-1:0] lk_set, f_set;
  logic [OFF_W-1:0] lk_off, f_off;
  logic [TAG_W-1:0] lk_tag, f_tag;

  assign lk_off = lk_w[OFF_W-1:0];
  assign lk_set = lk_w[TAG_L-1:OFF_W];
  assign lk_tag = lk_w[ADDR_W-3:TAG_L];
  assign f_off  = fill_w[OFF_W-1:0];
  assign f_set  = fill_w[TAG_L-1:OFF_W];
  assign f_tag  = fill_w[ADDR_W-3:TAG_L];

  // Per-line tag comparators
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  assign lk_hit  = hit_vec[lk_set];
  assign lk_data = data_q[lk_set][lk_off];

  // Valid bits: cleared at the start of a refill, set when it completes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fill_start && (f_set == SET_W'(i)))
          vld_q[i] <= 1'b0;
        else if (fill_done && (f_set == SET_W'(i)))
          vld_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done)
      tag_q[f_set] <= f_tag;
  end

  always_ff @(posedge clk) begin
    if (fill_we)
      data_q[f_set][f_off] <= fill_data;
  end
endmodule

// File: rtl/cblk_xlate.sv
module cblk_xlate
  import cblk_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CRD_W   = 10,
  parameter int ID_W    = 8,
  parameter int LINES   = 8,
  parameter int ENTRIES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-3:0]    req_table,
  input  logic [CRD_W-1:0]     req_col,
  input  logic [CRD_W-1:0]     req_row,
  input  logic [CRD_W-1:0]     req_bpr,
  input  logic [ID_W-1:0]      req_id,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ADDR_W-1:0]    mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [WORD_W-1:0]    mem_rsp_data,
  output logic                 out_valid,
  output logic [UNIT_W-1:0]    out_addr,
  output logic [ID_W-1:0]      out_id,
  output logic                 out_last
);
  localparam int OFF_W = $clog2(ENTRIES);

  xl_state_t state_q, state_d;

  logic [ADDR_W-3:0] table_q;
  logic [CRD_W-1:0]  col_q, row_q, bpr_q;
  logic [ID_W-1:0]   id_q;
  logic [OFF_W-1:0]  fk_q, fk_d;
  logic [UNIT_W-1:0] cur_q, cur_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              ov_q, ov_d, ol_q, ol_d;
  logic [UNIT_W-1:0] oa_q, oa_d;
  logic [ID_W-1:0]   oid_q, oid_d;

  logic              ld_req, walk_en, fk_en;
  logic [ADDR_W-3:0] ent_w, fill_w;
  logic              hit;
  logic [WORD_W-1:0] lk_data;
  ptr_ent_t          ent;
  logic              fill_start, fill_we, fill_done;
  logic [UNIT_W-1:0] nxt_unit;

  assign ld_req    = (state_q == ST_IDLE) && req_valid;
  assign req_ready = (state_q == ST_IDLE);

  cblk_addr_gen #(.ADDR_W(ADDR_W), .CRD_W(CRD_W)) u_agen (
    .table_w (table_q),
    .col     (col_q),
    .row     (row_q),
    .bpr     (bpr_q),
    .ent_w   (ent_w)
  );

  assign fill_w     = {ent_w[ADDR_W-3:OFF_W], fk_q};
  assign fill_start = (state_q == ST_LOOK) && !hit;
  assign fill_we    = (state_q == ST_FWAIT) && mem_rsp_valid;
  assign fill_done  = fill_we && (fk_q == OFF_W'(ENTRIES - 1));

  cblk_ptr_cache #(
    .ADDR_W(ADDR_W), .LINES(LINES), .ENTRIES(ENTRIES), .WORD_W(WORD_W)
  ) u_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_w       (ent_w),
    .lk_hit     (hit),
    .lk_data    (lk_data),
    .fill_start (fill_start),
    .fill_we    (fill_we),
    .fill_w     (fill_w),
    .fill_data  (mem_rsp_data),
    .fill_done  (fill_done)
  );

  assign ent      = ptr_ent_t'(lk_data);
  assign nxt_unit = mem_rsp_data[UNIT_W-1:0];

  assign mem_req_valid = (state_q == ST_FREQ) || (state_q == ST_NREQ);
  assign mem_req_addr  = (state_q == ST_FREQ) ? {fill_w, 2'b00} : ADDR_W'(cur_q);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    fk_d    = fk_q;
    cur_d   = cur_q;
    left_d  = left_q;
    ov_d    = 1'b0;
    oa_d    = oa_q;
    ol_d    = ol_q;
    oid_d   = oid_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) state_d = ST_LOOK;
      end
      ST_LOOK: begin
        if (hit) begin
          cur_d   = ent.unit;
          left_d  = ent.len;
          state_d = ST_WALK;
        end else begin
          fk_d    = '0;
          state_d = ST_FREQ;
        end
      end
      ST_FREQ: begin
        if (mem_req_ready) state_d = ST_FWAIT;
      end
      ST_FWAIT: begin
        if (mem_rsp_valid) begin
          if (fk_q == OFF_W'(ENTRIES - 1)) begin
            state_d = ST_LOOK;
          end else begin
            fk_d    = fk_q + OFF_W'(1);
            state_d = ST_FREQ;
          end
        end
      end
      ST_WALK: begin
        if (left_q == '0) begin
          state_d = ST_IDLE;
        end else if (left_q == LEN_W'(1)) begin
          ov_d    = 1'b1;
          oa_d    = cur_q;
          ol_d    = 1'b1;
          oid_d   = id_q;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_NREQ;
        end
      end
      ST_NREQ: begin
        if (mem_req_ready) state_d = ST_NWAIT;
      end
      ST_NWAIT: begin
        if (mem_rsp_valid) begin
          ov_d  = 1'b1;
          oa_d  = cur_q;
          ol_d  = (nxt_unit == '0);
          oid_d = id_q;
          if (nxt_unit == '0) begin
            state_d = ST_IDLE;
          end else begin
            cur_d   = nxt_unit;
            left_d  = left_q - LEN_W'(1);
            state_d = ST_WALK;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign walk_en = (state_q == ST_LOOK) || (state_q == ST_NWAIT);
  assign fk_en   = (state_q == ST_LOOK) || (state_q == ST_FWAIT);

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ov_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ov_q    <= ov_d;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (ld_req) begin
      table_q <= req_table;
      col_q   <= req_col;
      row_q   <= req_row;
      bpr_q   <= req_bpr;
      id_q    <= req_id;
    end
    if (fk_en) fk_q <= fk_d;
    if (walk_en) begin
      cur_q  <= cur_d;
      left_q <= left_d;
    end
    if (ov_d) begin
      oa_q  <= oa_d;
      ol_q  <= ol_d;
      oid_q <= oid_d;
    end
  end

  assign out_valid = ov_q;
  assign out_addr  = oa_q;
  assign out_last  = ol_q;
  assign out_id    = oid_q;
endmodule

// File: rtl/cblk_xlate_chk.sv
module cblk_xlate_chk #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ID_W-1:0]   req_id,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              out_valid,
  input logic [ID_W-1:0]   out_id,
  input logic              out_last
);
  logic            pend_q;
  logic [ID_W-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tag_q  <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) pend_q <= 1'b1;
      else if (mem_rsp_valid)             pend_q <= 1'b0;
      if (req_valid && req_ready) tag_q <= req_id;
    end
  end

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_ready_with_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> req_ready);

  assert_out_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_id == tag_q));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_single_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !mem_req_valid);
endmodule

bind cblk_xlate cblk_xlate_chk #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_id        (req_id),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .out_valid     (out_valid),
  .out_id        (out_id),
  .out_last      (out_last)
);

// File: tb/cblk_xlate_tb.sv
`timescale 1ns/1ps
module cblk_xlate_tb;
  typedef struct packed {
    logic [29:0] tbl;
    logic [9:0]  col;
    logic [9:0]  row;
    logic [9:0]  bpr;
    logic        fill;
    logic        slow;
  } vec_t;

  // table word, column, row, blocks/row, expect refill, slow memory
  localparam vec_t VEC [9] = '{
    '{30'h0,  10'd0, 10'd0, 10'd8, 1'b1, 1'b0},
    '{30'h0,  10'd5, 10'd0, 10'd8, 1'b0, 1'b1},
    '{30'h0,  10'd1, 10'd1, 10'd8, 1'b1, 1'b0},
    '{30'h0,  10'd2, 10'd1, 10'd8, 1'b0, 1'b0},
    '{30'h10, 10'd1, 10'd0, 10'd4, 1'b1, 1'b1},
    '{30'h0,  10'd1, 10'd2, 10'd8, 1'b0, 1'b0},
    '{30'h0,  10'd0, 10'd8, 10'd8, 1'b1, 1'b0},
    '{30'h0,  10'd0, 10'd0, 10'd8, 1'b1, 1'b1},
    '{30'h0,  10'd3, 10'd5, 10'd3, 1'b0, 1'b0}
  };

  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [29:0] req_table;
  logic [9:0]  req_col, req_row, req_bpr;
  logic [7:0]  req_id;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        out_valid, out_last;
  logic [23:0] out_addr;
  logic [7:0]  out_id;

  cblk_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_table(req_table), .req_col(req_col), .req_row(req_row),
    .req_bpr(req_bpr), .req_id(req_id),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_addr(out_addr), .out_id(out_id),
    .out_last(out_last)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk, n_fail;
  logic [31:0] mem [1024];
  logic        slow;

  // observation, written only by the monitor and the memory model
  int          o_tot, fill_tot, unit_tot;
  logic [23:0] o_addr [256];
  logic        o_last [256];
  logic [7:0]  o_id   [256];
  logic [31:0] fa     [256];
  int          s_o, s_f, s_u;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // output monitor
  initial begin
    o_tot = 0;
    forever begin
      @(negedge clk);
      if (out_valid) begin
        o_addr[o_tot[7:0]] = out_addr;
        o_last[o_tot[7:0]] = out_last;
        o_id[o_tot[7:0]]   = out_id;
        o_tot++;
      end
    end
  end

  // memory model: one read in flight, optional stalls and latency
  initial begin
    logic        pend, tgl;
    logic [31:0] paddr;
    int          dly;
    pend = 0; tgl = 0; dly = 0; paddr = 0;
    fill_tot = 0; unit_tot = 0;
    mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (!rst_n) pend = 0;
      else if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem[paddr[11:2]];
          pend = 0;
        end else dly--;
      end
      tgl = ~tgl;
      mem_req_ready = slow ? tgl : 1'b1;
      if (rst_n && mem_req_valid && mem_req_ready && !pend && !mem_rsp_valid) begin
        pend  = 1;
        paddr = mem_req_addr;
        dly   = slow ? 2 : 0;
        if (mem_req_addr < 32'h200) begin
          fa[fill_tot[7:0]] = mem_req_addr;
          fill_tot++;
        end else unit_tot++;
      end
    end
  end

  task automatic run_block(input vec_t vc, input logic [7:0] id);
    logic [29:0] w;
    logic [31:0] e;
    logic [23:0] cur, nxt;
    logic [23:0] ea [16];
    int n, en, er;
    bit done;
    w = vc.tbl + 30'(vc.row) * 30'(vc.bpr) + 30'(vc.col);
    e = mem[w[9:0]];
    cur = e[23:0]; n = int'(e[31:24]); en = 0; er = 0; done = 0;
    while (n > 0 && !done) begin
      ea[en] = cur; en++;
      if (n == 1) done = 1;
      else begin
        nxt = mem[cur[11:2]][23:0]; er++;
        if (nxt == '0) done = 1;
        else begin cur = nxt; n--; end
      end
    end
    s_o = o_tot; s_f = fill_tot; s_u = unit_tot;
    slow = vc.slow;
    req_table = vc.tbl; req_col = vc.col; req_row = vc.row; req_bpr = vc.bpr;
    req_id = id; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(req_ready == 1'b0, "R1 busy after accept", 32'(req_ready), 32'h0);
    while (!req_ready) @(negedge clk);
    #1;
    chk((fill_tot - s_f) == (vc.fill ? 8 : 0), "R3 table read count",
        32'(fill_tot - s_f), vc.fill ? 32'd8 : 32'd0);
    if (vc.fill) begin
      chk(fa[s_f[7:0]] == {w[29:3], 5'b0}, "R2 first table read address",
          fa[s_f[7:0]], {w[29:3], 5'b0});
      chk(fa[(s_f + 7) & 255] == {w[29:3], 5'b11100}, "R3 last table read address",
          fa[(s_f + 7) & 255], {w[29:3], 5'b11100});
    end
    chk((unit_tot - s_u) == er, "R5 link read count", 32'(unit_tot - s_u), 32'(er));
    chk((o_tot - s_o) == en, "R4 unit count", 32'(o_tot - s_o), 32'(en));
    for (int i = 0; i < en && i < (o_tot - s_o); i++) begin
      chk(o_addr[(s_o + i) & 255] == ea[i], "R4 unit address",
          32'(o_addr[(s_o + i) & 255]), 32'(ea[i]));
      chk(o_last[(s_o + i) & 255] == (i == en - 1), "R8 last flag",
          32'(o_last[(s_o + i) & 255]), 32'(i == en - 1));
      chk(o_id[(s_o + i) & 255] == id, "R8 id tag",
          32'(o_id[(s_o + i) & 255]), 32'(id));
    end
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; slow = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_table = '0;
    req_col = '0; req_row = '0; req_bpr = '0; req_id = '0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < 72; i++) mem[i] = {8'd1, 24'h000800 + 24'(i) * 24'd128};
    mem[0]   = {8'd3, 24'h000200};
    mem[128] = 32'hAB000280;        // upper byte must be ignored (R4)
    mem[160] = 32'h00000300;
    mem[5]   = {8'd5, 24'h000400};
    mem[256] = 32'h00000480;
    mem[288] = 32'h00000000;        // early end (R6)
    mem[9]   = {8'd0, 24'h000A00};  // empty block (R7)
    mem[10]  = {8'd1, 24'h000500};
    mem[17]  = {8'd2, 24'h000600};
    mem[384] = 32'h00000680;
    mem[416] = 32'h00000700;
    mem[64]  = {8'd1, 24'h000900};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 32'h1);
    chk(out_valid == 1'b0, "R10 no output after reset", 32'(out_valid), 32'h0);
    chk(mem_req_valid == 1'b0, "R10 no read after reset", 32'(mem_req_valid), 32'h0);

    for (int v = 0; v < 9; v++) begin
      run_block(VEC[v], 8'h10 + 8'(v));
      if (v == 1)
        chk((o_tot - s_o) == 2 && o_last[(s_o + 1) & 255],
            "R6 zero link ends chain", 32'(o_tot - s_o), 32'h2);
      if (v == 2)
        chk((o_tot - s_o) == 0, "R7 empty block", 32'(o_tot - s_o), 32'h0);
      if (v == 7)
        chk((fill_tot - s_f) == 8, "R3 conflict eviction refill",
            32'(fill_tot - s_f), 32'h8);
    end

    // reset in the middle of a walk
    slow = 1'b0;
    req_table = '0; req_col = '0; req_row = '0; req_bpr = 10'd8;
    req_id = 8'h77; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(req_ready == 1'b1, "R10 ready in reset", 32'(req_ready), 32'h1);
    chk(out_valid == 1'b0, "R10 output idle in reset", 32'(out_valid), 32'h0);
    chk(mem_req_valid == 1'b0, "R10 read idle in reset", 32'(mem_req_valid), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    run_block(VEC[0], 8'h55);
    chk((fill_tot - s_f) == 8, "R10 cache emptied by reset",
        32'(fill_tot - s_f), 32'h8);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule